// File: doc/BRIEF.md
# Page-Mode DRAM Access and Refresh Sequencer

This block drives the strobes of an asynchronous fast-page-mode or EDO DRAM: row strobe, column strobe, write enable and the shared row/column address lines. A host raises a request with an address and a direction. The block opens the row and runs a four-beat page-mode burst inside that row. It signals each beat with a one-cycle acknowledge. On a read the captured data is returned with that acknowledge. On a write the host's data word is driven for that beat.

Six timing values come in on configuration inputs: row precharge, row-to-column delay, first column pulse width, column precharge, page-mode column pulse width, and the refresh interval. Software programs them while the enable input is low. The block copies them into working registers while it is disabled and holds that copy for as long as it stays enabled. Once enabled, it first precharges. It then runs column-before-row refresh cycles from an interval timer and accepts host traffic only after eight of those refreshes have started. A configuration whose column-to-column spacing inside a burst would be too long is reported on a flag.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While the block is disabled (from reset, or after `mem_en` falls and the block reaches idle), `ras_n` and `cas_n` stay high, `init_done` is low and requests are ignored.
- R2: With interval value N (0 counts as 1), a pending refresh is raised every N cycles of the enabled timer. A refresh drives `cas_n` low for 1 cycle with `ras_n` high. It then holds both low for rcd+cas1 cycles, followed by rp cycles with both high and one idle cycle.
- R3: `init_done` rises in the cycle after the eighth refresh of an enable period starts. No row is opened before that point.
- R4: An accepted access first drives `ras_n` low with `cas_n` high for rcd cycles, with `ma` carrying the row. The row is `req_addr[2*MA_W-1:MA_W]`.
- R5: A burst is four column pulses with `ras_n` held low. The first pulse lasts cas1 cycles and the others last casp cycles, with cp cycles of `cas_n` high between pulses. Column bits `[1:0]` equal the request's `req_addr[1:0]` plus the beat number, modulo 4. The upper column bits stay fixed. During each gap `ma` already shows the next column.
- R6: `ack` pulses in the cycle after each column pulse ends, and `ack_last` pulses with the fourth one. On a read, `rdata` holds the `dq_in` value from the last cycle of that pulse.
- R7: On a write, `we_n` is low and `dq_oe` is high in exactly the cycles of each column pulse, and `dq_out` equals `req_wdata`. On a read, `we_n` stays high and `dq_oe` stays low.
- R8: A pending refresh wins over a waiting request when the block is idle. A refresh never starts inside a burst.
- R9: Changes to the configuration inputs while enabled have no effect until the block is disabled and enabled again.
- R10: `cfg_err` is high while enabled exactly when max(cas1, casp) + cp exceeds 8 clock cycles.
- R11: A timing value of 0 behaves as 1 cycle.
- R12: After the enable edge, `ras_n` and `cas_n` stay high for rp cycles plus one idle cycle before any refresh or access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every output changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_en | input | 1 | Memory enable set by software after programming |
| cfg_rp | input | TW | Row precharge cycles |
| cfg_rcd | input | TW | Row-to-column delay cycles |
| cfg_cas1 | input | TW | First column pulse width |
| cfg_cp | input | TW | Column precharge cycles between beats |
| cfg_casp | input | TW | Page-mode column pulse width |
| cfg_refint | input | RW | Refresh interval in cycles |
| req | input | 1 | Access request, held until `ack_last` |
| req_we | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 2*MA_W | Row in upper half, starting column in lower half |
| req_wdata | input | DW | Write data for the current beat |
| ack | output | 1 | Beat acknowledge |
| ack_last | output | 1 | Fourth-beat acknowledge |
| rdata | output | DW | Read data valid with `ack` |
| init_done | output | 1 | Warm-up refreshes complete |
| cfg_err | output | 1 | Burst spacing exceeds the limit |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ma | output | MA_W | Multiplexed row/column address |
| dq_out | output | DW | Data to DRAM |
| dq_oe | output | 1 | Data output enable |
| dq_in | input | DW | Data from DRAM |

## Verification
The assertions assume that the host holds `req`, `req_we` and `req_addr` steady from raising the request until `ack_last`. They also assume that `req_wdata` changes only in the cycle after an `ack`, never during a column pulse. The bench's host task changes these inputs only on falling edges, and only after seeing `ack` or `ack_last`. Configuration inputs may change at any time. That freedom is what the frozen-copy check relies on, so the bench also rewrites the timing values in the middle of enabled traffic. It lowers `mem_en` only between bursts, because the block finishes its current cycle first anyway.

// File: rtl/edo_dram_pkg.sv
package edo_dram_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PRE   = 3'd1,
    ST_IDLE  = 3'd2,
    ST_REFC  = 3'd3,
    ST_REFRC = 3'd4,
    ST_ROW   = 3'd5,
    ST_CAS   = 3'd6,
    ST_CPRE  = 3'd7
  } dram_st_e;

  // a programmed zero is stretched to one cycle
  function automatic int unsigned eff_cycles(input int unsigned raw);
    return (raw == 0) ? 32'd1 : raw;
  endfunction

  // worst strobe-to-strobe spacing inside a burst against the limit
  function automatic logic gap_too_long(input int unsigned first_w,
                                        input int unsigned page_w,
                                        input int unsigned pre_w,
                                        input int unsigned limit);
    int unsigned worst;
    worst = (first_w > page_w) ? first_w : page_w;
    return (worst + pre_w) > limit;
  endfunction

  // low column bits for a beat, wrapping inside the aligned group of four
  function automatic logic [1:0] beat_col(input logic [1:0] start, input logic [1:0] beat);
    return start + beat;
  endfunction

endpackage

// File: rtl/edo_dram_tim_shadow.sv
module edo_dram_tim_shadow #(
  parameter int TW      = 4,
  parameter int RW      = 12,
  parameter int MAX_GAP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          track,
  input  logic [TW-1:0] in_rp,
  input  logic [TW-1:0] in_rcd,
  input  logic [TW-1:0] in_cas1,
  input  logic [TW-1:0] in_cp,
  input  logic [TW-1:0] in_casp,
  input  logic [RW-1:0] in_ref,
  output logic [TW-1:0] use_rp,
  output logic [TW-1:0] use_rcd,
  output logic [TW-1:0] use_cas1,
  output logic [TW-1:0] use_cp,
  output logic [TW-1:0] use_casp,
  output logic [RW-1:0] use_ref,
  output logic          gap_err,
  output logic [5*TW+RW-1:0] snap
);
  import edo_dram_pkg::*;

  logic [TW-1:0] sh_rp, sh_rcd, sh_cas1, sh_cp, sh_casp;
  logic [RW-1:0] sh_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_rp   <= '0;
      sh_rcd  <= '0;
      sh_cas1 <= '0;
      sh_cp   <= '0;
      sh_casp <= '0;
      sh_ref  <= '0;
    end else if (track) begin
      sh_rp   <= in_rp;
      sh_rcd  <= in_rcd;
      sh_cas1 <= in_cas1;
      sh_cp   <= in_cp;
      sh_casp <= in_casp;
      sh_ref  <= in_ref;
    end
  end

  // while tracking, loads see the live inputs so the enable edge uses them
  assign use_rp   = track ? in_rp   : sh_rp;
  assign use_rcd  = track ? in_rcd  : sh_rcd;
  assign use_cas1 = track ? in_cas1 : sh_cas1;
  assign use_cp   = track ? in_cp   : sh_cp;
  assign use_casp = track ? in_casp : sh_casp;
  assign use_ref  = track ? in_ref  : sh_ref;

  assign gap_err = gap_too_long(eff_cycles(32'(sh_cas1)), eff_cycles(32'(sh_casp)),
                                eff_cycles(32'(sh_cp)), MAX_GAP);
  assign snap = {sh_rp, sh_rcd, sh_cas1, sh_cp, sh_casp, sh_ref};

endmodule

// File: rtl/edo_dram_refresh.sv
module edo_dram_refresh #(
  parameter int RW   = 12,
  parameter int WARM = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] interval,
  input  logic          take,
  output logic          pend,
  output logic          ready,
  output logic          expire
);
  import edo_dram_pkg::*;

  localparam int WW = $clog2(WARM + 1);

  logic [RW-1:0] tmr_q;
  logic [WW-1:0] warm_q;
  logic [RW-1:0] reload;

  assign reload = RW'(eff_cycles(32'(interval)) - 1);
  assign expire = run && (tmr_q == '0);
  assign ready  = (warm_q == WW'(WARM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend   <= 1'b0;
      warm_q <= '0;
    end else if (!run) begin
      tmr_q  <= reload;
      pend   <= 1'b0;
      warm_q <= '0;
    end else begin
      tmr_q <= expire ? reload : tmr_q - 1'b1;
      if (expire)    pend <= 1'b1;
      else if (take) pend <= 1'b0;
      if (take && !ready) warm_q <= warm_q + 1'b1;
    end
  end

endmodule

// File: rtl/edo_dram_addr_mux.sv
module edo_dram_addr_mux #(
  parameter int MA_W = 8
) (
  input  logic [MA_W-1:0] row,
  input  logic [MA_W-1:0] col_base,
  input  logic [1:0]      beat,
  input  logic            pick_row,
  output logic [MA_W-1:0] ma
);
  import edo_dram_pkg::*;

  logic [MA_W-1:0] col_now;

  assign col_now = {col_base[MA_W-1:2], beat_col(col_base[1:0], beat)};
  assign ma      = pick_row ? row : col_now;

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int TW      = 4,
  parameter int RW      = 12,
  parameter int MA_W    = 8,
  parameter int DW      = 16,
  parameter int MAX_GAP = 8,
  parameter int WARM    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_en,
  input  logic [TW-1:0]   cfg_rp,
  input  logic [TW-1:0]   cfg_rcd,
  input  logic [TW-1:0]   cfg_cas1,
  input  logic [TW-1:0]   cfg_cp,
  input  logic [TW-1:0]   cfg_casp,
  input  logic [RW-1:0]   cfg_refint,
  input  logic            req,
  input  logic            req_we,
  input  logic [2*MA_W-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            ack,
  output logic            ack_last,
  output logic [DW-1:0]   rdata,
  output logic            init_done,
  output logic            cfg_err,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [MA_W-1:0] ma,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  input  logic [DW-1:0]   dq_in
);
  import edo_dram_pkg::*;

  localparam int CW     = TW + 2;
  localparam int SNAP_W = 5 * TW + RW;

  dram_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [1:0]      beat_q, beat_d;
  logic [MA_W-1:0] row_q, col_q;
  logic            wr_q;
  logic            ack_q, last_q;
  logic [DW-1:0]   rdata_q;

  // named internal events, observed by the bound checker
  logic            engine_on;
  logic            refresh_start;
  logic            access_start;
  logic            cas_end;
  logic            cnt_done;
  logic [SNAP_W-1:0] tim_snapshot;

  logic [TW-1:0]   u_rp, u_rcd, u_cas1, u_cp, u_casp;
  logic [RW-1:0]   u_ref;
  logic            ref_pend, warm_ok, ref_expire;
  logic [CW-1:0]   ld_rp, ld_rcd, ld_cas1, ld_cp, ld_casp, ld_refrc;

  assign engine_on = (st_q != ST_OFF);
  assign cnt_done  = (cnt_q == '0);

  edo_dram_tim_shadow #(.TW(TW), .RW(RW), .MAX_GAP(MAX_GAP)) u_shadow (
    .clk(clk), .rst_n(rst_n), .track(!engine_on),
    .in_rp(cfg_rp), .in_rcd(cfg_rcd), .in_cas1(cfg_cas1),
    .in_cp(cfg_cp), .in_casp(cfg_casp), .in_ref(cfg_refint),
    .use_rp(u_rp), .use_rcd(u_rcd), .use_cas1(u_cas1),
    .use_cp(u_cp), .use_casp(u_casp), .use_ref(u_ref),
    .gap_err(cfg_err), .snap(tim_snapshot)
  );

  edo_dram_refresh #(.RW(RW), .WARM(WARM)) u_refresh (
    .clk(clk), .rst_n(rst_n), .run(engine_on), .interval(u_ref),
    .take(refresh_start), .pend(ref_pend), .ready(warm_ok), .expire(ref_expire)
  );

  // counter load values: a phase of n cycles loads n-1
  assign ld_rp    = CW'(eff_cycles(32'(u_rp)) - 1);
  assign ld_rcd   = CW'(eff_cycles(32'(u_rcd)) - 1);
  assign ld_cas1  = CW'(eff_cycles(32'(u_cas1)) - 1);
  assign ld_cp    = CW'(eff_cycles(32'(u_cp)) - 1);
  assign ld_casp  = CW'(eff_cycles(32'(u_casp)) - 1);
  assign ld_refrc = CW'(eff_cycles(32'(u_rcd)) + eff_cycles(32'(u_cas1)) - 1);

  assign cas_end = (st_q == ST_CAS) && cnt_done;

  always_comb begin
    st_d          = st_q;
    cnt_d         = cnt_done ? cnt_q : cnt_q - 1'b1;
    beat_d        = beat_q;
    refresh_start = 1'b0;
    access_start  = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        if (mem_en) begin
          st_d  = ST_PRE;
          cnt_d = ld_rp;
        end
      end
      ST_PRE: begin
        if (cnt_done) st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!mem_en) begin
          st_d = ST_OFF;
        end else if (ref_pend) begin
          st_d          = ST_REFC;
          cnt_d         = '0;
          refresh_start = 1'b1;
        end else if (warm_ok && req) begin
          st_d         = ST_ROW;
          cnt_d        = ld_rcd;
          beat_d       = 2'd0;
          access_start = 1'b1;
        end
      end
      ST_REFC: begin
        st_d  = ST_REFRC;
        cnt_d = ld_refrc;
      end
      ST_REFRC: begin
        if (cnt_done) begin
          st_d  = ST_PRE;
          cnt_d = ld_rp;
        end
      end
      ST_ROW: begin
        if (cnt_done) begin
          st_d  = ST_CAS;
          cnt_d = ld_cas1;
        end
      end
      ST_CAS: begin
        if (cnt_done) begin
          if (beat_q == 2'd3) begin
            st_d  = ST_PRE;
            cnt_d = ld_rp;
          end else begin
            st_d   = ST_CPRE;
            cnt_d  = ld_cp;
            beat_d = beat_q + 1'b1;
          end
        end
      end
      ST_CPRE: begin
        if (cnt_done) begin
          st_d  = ST_CAS;
          cnt_d = ld_casp;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      cnt_q   <= '0;
      beat_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      last_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      ack_q  <= cas_end;
      last_q <= cas_end && (beat_q == 2'd3);
      if (access_start) begin
        row_q <= req_addr[2*MA_W-1:MA_W];
        col_q <= req_addr[MA_W-1:0];
        wr_q  <= req_we;
      end
      if (cas_end && !wr_q) rdata_q <= dq_in;
    end
  end

  edo_dram_addr_mux #(.MA_W(MA_W)) u_amux (
    .row(row_q), .col_base(col_q), .beat(beat_q),
    .pick_row(st_q == ST_ROW), .ma(ma)
  );

  assign ras_n     = !((st_q == ST_REFRC) || (st_q == ST_ROW) ||
                       (st_q == ST_CAS)   || (st_q == ST_CPRE));
  assign cas_n     = !((st_q == ST_REFC) || (st_q == ST_REFRC) || (st_q == ST_CAS));
  assign dq_oe     = (st_q == ST_CAS) && wr_q;
  assign we_n      = !dq_oe;
  assign dq_out    = req_wdata;
  assign ack       = ack_q;
  assign ack_last  = last_q;
  assign rdata     = rdata_q;
  assign init_done = warm_ok && engine_on;

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int MAX_GAP = 8,
  parameter int SNAP_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic              ack,
  input logic              ack_last,
  input logic              init_done,
  input logic              cfg_err,
  input logic              engine_on,
  input logic [SNAP_W-1:0] tim_snapshot
);

  logic       cas_prev;
  logic       burst_open;
  logic [7:0] gap_q;
  logic       cas_fall;

  assign cas_fall = !cas_n && cas_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_prev   <= 1'b1;
      burst_open <= 1'b0;
      gap_q      <= '0;
    end else begin
      cas_prev <= cas_n;
      if (ras_n)                 burst_open <= 1'b0;
      else if (cas_fall)         burst_open <= 1'b1;
      if (cas_fall)              gap_q <= 8'd1;
      else if (gap_q != 8'hFF)   gap_q <= gap_q + 1'b1;
    end
  end

  // R1: nothing toggles on the DRAM while the engine is off
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !engine_on |-> (ras_n && cas_n));

  // R3: a row is opened for an access only after warm-up
  a_r3_no_row_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && cas_n) |-> init_done);

  // R2: refresh lowers the column strobe ahead of the row strobe
  a_r2_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  // R6: an acknowledge follows a column pulse
  a_r6_ack_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(!cas_n && !ras_n));

  // R6: the final acknowledge is also a beat acknowledge
  a_r6_last_is_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_last |-> ack);

  // R7: write enable only inside a column pulse of an open row
  a_r7_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cas_n && !ras_n && dq_oe));

  // R9: working timing copy frozen while enabled
  a_r9_timing_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (engine_on && $past(engine_on)) |-> $stable(tim_snapshot));

  // R10: a legal configuration keeps strobe spacing within the limit
  a_r10_gap_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && burst_open && !cfg_err) |-> (gap_q <= 8'(MAX_GAP)));

endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.MAX_GAP(MAX_GAP), .SNAP_W(5*TW+RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dq_oe(dq_oe), .ack(ack), .ack_last(ack_last), .init_done(init_done),
  .cfg_err(cfg_err), .engine_on(engine_on), .tim_snapshot(tim_snapshot)
);

// File: tb/sim_edo_dram_ctrl.sv
module sim_edo_dram_ctrl;
  localparam int TW = 4, RW = 12, MA_W = 8, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, mem_en = 1'b0;
  logic [TW-1:0] cfg_rp = '0, cfg_rcd = '0, cfg_cas1 = '0, cfg_cp = '0, cfg_casp = '0;
  logic [RW-1:0] cfg_refint = '0;
  logic req = 1'b0, req_we = 1'b0;
  logic [2*MA_W-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ack, ack_last, init_done, cfg_err, ras_n, cas_n, we_n, dq_oe;
  logic [DW-1:0] rdata, dq_out, dq_in;
  logic [MA_W-1:0] ma;

  always #5 clk = ~clk;

  edo_dram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en),
    .cfg_rp(cfg_rp), .cfg_rcd(cfg_rcd), .cfg_cas1(cfg_cas1), .cfg_cp(cfg_cp),
    .cfg_casp(cfg_casp), .cfg_refint(cfg_refint),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .ack_last(ack_last), .rdata(rdata), .init_done(init_done),
    .cfg_err(cfg_err), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ma(ma),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  function automatic logic [DW-1:0] rpat(input int m);
    return {~8'(m), 8'(m)};
  endfunction
  function automatic logic [DW-1:0] wpat(input int a, input int b);
    return 16'(a * 7 + b * 4099 + 3);
  endfunction
  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  assign dq_in = rpat(int'(ma));

  int compared = 0, mismatched = 0, cyc = 0;

  typedef struct {
    bit ras, cas, we, oe, ack, last, ma_chk;
    int ma;
    logic [DW-1:0] rd, wd;
    string tag;
  } ent_t;

  ent_t q[$];
  ent_t exp_now;
  bit   m_en, pend;
  int   tmr, refcnt;
  int   l_rp, l_rcd, l_cas1, l_cp, l_casp, l_ref;
  bit   l_err, l_zero;
  bit   ack_due, last_due;
  logic [DW-1:0] rd_due;

  function automatic ent_t idle_ent(input string t);
    ent_t e;
    e.ras = 1; e.cas = 1; e.we = 1; e.oe = 0; e.ack = 0; e.last = 0;
    e.ma_chk = 0; e.ma = 0; e.rd = '0; e.wd = '0; e.tag = t;
    return e;
  endfunction

  function automatic string tagf(input string base);
    if (l_zero) return "R11";
    if (cfg_rp != TW'(l_rp) || cfg_casp != TW'(l_casp) || cfg_cp != TW'(l_cp) ||
        cfg_rcd != TW'(l_rcd) || cfg_cas1 != TW'(l_cas1) || cfg_refint != RW'(l_ref))
      return "R9";
    return base;
  endfunction

  task automatic add(input ent_t e);
    if (ack_due) begin
      e.ack = 1; e.last = last_due; e.rd = rd_due; e.tag = tagf("R6");
      ack_due = 0;
    end
    q.push_back(e);
  endtask

  task automatic add_pre();
    for (int i = 0; i < eff(l_rp); i++) add(idle_ent(tagf("R12")));
    add(idle_ent(tagf("R12")));
  endtask

  task automatic add_refresh(input string t);
    ent_t e;
    e = idle_ent(t); e.cas = 0; add(e);
    for (int i = 0; i < eff(l_rcd) + eff(l_cas1); i++) begin
      e = idle_ent(t); e.ras = 0; e.cas = 0; add(e);
    end
    add_pre();
  endtask

  task automatic add_access(input int addr, input bit wr);
    ent_t e;
    int row, c0, col, nxt;
    row = addr >> MA_W; c0 = addr & 8'hFF;
    for (int i = 0; i < eff(l_rcd); i++) begin
      e = idle_ent(tagf("R4")); e.ras = 0; e.ma_chk = 1; e.ma = row; add(e);
    end
    for (int b = 0; b < 4; b++) begin
      col = (c0 & 8'hFC) | ((c0 + b) & 3);
      nxt = (c0 & 8'hFC) | ((c0 + b + 1) & 3);
      for (int i = 0; i < ((b == 0) ? eff(l_cas1) : eff(l_casp)); i++) begin
        e = idle_ent(tagf(wr ? "R7" : "R5"));
        e.ras = 0; e.cas = 0; e.we = !wr; e.oe = wr; e.ma_chk = 1; e.ma = col;
        e.wd = wpat(addr, b); add(e);
      end
      ack_due = 1; last_due = (b == 3); rd_due = wr ? rdata : rpat(col);
      if (b < 3)
        for (int i = 0; i < eff(l_cp); i++) begin
          e = idle_ent(tagf("R5")); e.ras = 0; e.ma_chk = 1; e.ma = nxt; add(e);
        end
    end
    add_pre();
  endtask

  // reference model, one step per rising edge, using the inputs seen at that edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_en = 0; pend = 0; tmr = 0; refcnt = 0; ack_due = 0;
      exp_now = idle_ent("R1");
    end else begin
      bit was_en;
      was_en = m_en;
      if (q.size() == 0) begin
        if (!m_en) begin
          if (mem_en) begin
            l_rp = int'(cfg_rp); l_rcd = int'(cfg_rcd); l_cas1 = int'(cfg_cas1);
            l_cp = int'(cfg_cp); l_casp = int'(cfg_casp); l_ref = int'(cfg_refint);
            l_zero = (l_rp == 0) || (l_rcd == 0) || (l_cas1 == 0) || (l_cp == 0) ||
                     (l_casp == 0) || (l_ref == 0);
            l_err = ((eff(l_cas1) > eff(l_casp) ? eff(l_cas1) : eff(l_casp)) + eff(l_cp)) > 8;
            m_en = 1;
            add_pre();
          end
        end else if (!mem_en) begin
          m_en = 0;
        end else if (pend) begin
          pend = 0; refcnt++;
          add_refresh(req ? "R8" : tagf("R2"));
        end else if (refcnt >= 8 && req) begin
          add_access(int'(req_addr), req_we);
        end
      end
      if (!was_en) begin
        tmr = eff(int'(cfg_refint)) - 1; pend = 0; refcnt = 0;
      end else if (tmr == 0) begin
        pend = 1; tmr = eff(l_ref) - 1;
      end else tmr--;
      if (q.size() != 0) exp_now = q.pop_front();
      else exp_now = idle_ent(m_en ? "R3" : "R1");
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      ent_t e;
      bit ok;
      e = exp_now;
      ok = (ras_n == e.ras) && (cas_n == e.cas) && (we_n == e.we) && (dq_oe == e.oe) &&
           (ack == e.ack) && (ack_last == e.last) &&
           (!e.ma_chk || int'(ma) == e.ma) &&
           (!(e.ack && e.we) || rdata == e.rd) &&
           (!e.oe || dq_out == e.wd) &&
           (init_done == (m_en && refcnt >= 8)) &&
           (!m_en || cfg_err == l_err);
      chk(ok, e.tag, "pins{ras,cas,we,oe,ack,last,ma,init}",
          {ras_n, cas_n, we_n, dq_oe, ack, ack_last, 8'(ma), init_done},
          {e.ras, e.cas, e.we, e.oe, e.ack, e.last, 8'(e.ma), (m_en && refcnt >= 8)});
    end
  end

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  task automatic access(input int addr, input bit wr);
    int b;
    b = 0;
    @(negedge clk);
    req = 1; req_we = wr; req_addr = 16'(addr); req_wdata = wpat(addr, 0);
    forever begin
      @(negedge clk);
      if (ack) begin
        b++;
        req_wdata = wpat(addr, b);
        if (ack_last) break;
      end
    end
    req = 0;
  endtask

  task automatic set_cfg(input int rp, rcd, c1, cp, cp2, rf);
    cfg_rp = TW'(rp); cfg_rcd = TW'(rcd); cfg_cas1 = TW'(c1);
    cfg_cp = TW'(cp); cfg_casp = TW'(cp2); cfg_refint = RW'(rf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(ras_n && cas_n && we_n && !ack && !init_done && !dq_oe, "R1", "reset pins",
        {ras_n, cas_n, init_done}, 3'b110);
    rst_n = 1;
    // R1: requests with the block disabled are ignored
    req = 1; req_addr = 16'h1234;
    repeat (20) @(negedge clk);
    chk(ras_n && cas_n && !init_done, "R1", "disabled ignores req", {ras_n, cas_n}, 2'b11);
    req = 0;

    set_cfg(2, 2, 3, 1, 2, 40);
    @(negedge clk); mem_en = 1;
    // R3: request raised immediately waits for warm-up
    access(16'h3A02, 0);
    chk(init_done == 1'b1, "R3", "ready after warm-up", init_done, 1);
    chk(cfg_err == 1'b0, "R10", "legal spacing flag", cfg_err, 0);
    for (int i = 0; i < 10; i++) access(16'h0100 * i + i * 5 + 1, (i % 2) == 1);

    // R9: reprogram while enabled
    set_cfg(5, 4, 6, 3, 5, 17);
    for (int i = 0; i < 4; i++) access(16'h5503 + i, i[0]);

    // R11: zero values behave as one cycle
    mem_en = 0;
    repeat (40) @(negedge clk);
    chk(!init_done, "R1", "init_done after disable", init_done, 0);
    set_cfg(0, 0, 0, 0, 0, 0);
    @(negedge clk); mem_en = 1;
    repeat (30) @(negedge clk);
    set_cfg(0, 1, 0, 0, 0, 25);
    mem_en = 0;
    repeat (20) @(negedge clk);
    @(negedge clk); mem_en = 1;
    for (int i = 0; i < 4; i++) access(16'hC0FD + i * 3, !i[0]);

    // R10: page pulse 7 plus precharge 2 exceeds the limit
    mem_en = 0;
    repeat (40) @(negedge clk);
    set_cfg(1, 2, 3, 2, 7, 60);
    @(negedge clk); mem_en = 1;
    repeat (4) @(negedge clk);
    chk(cfg_err == 1'b1, "R10", "spacing flag", cfg_err, 1);
    access(16'h7706, 1);
    access(16'h7707, 0);
    mem_en = 0;
    repeat (40) @(negedge clk);
    finish_up();
  end

endmodule